// File: doc/BRIEF.md
# DRAM Sub-Array Access Sequencer

This block steps one DRAM sub-array through a single read, write or refresh access by raising and lowering its internal control strobes in a fixed order. The order is: precharge with both equalizers, isolation switch and word-line boost, word line, first and then second sense-amplifier stage, and column select together with the read or write amplifier. The strobes are then released in the reverse order, the equalizers are restored, and a one-cycle completion pulse is given. The analog bit-line, pump and amplifier behaviour lies outside the block. It only orders and times the digital enables.

A requester pulses `start_i` while the block is idle and gives the operation code and six per-phase durations. These values are captured at that edge. Each programmed phase lasts the programmed number of clock cycles, and a programmed zero counts as one. A refresh runs the same sequence but skips the column phase. `busy_o` spans the whole access, including the completion cycle.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset, and whenever idle, only `eq_bl_o` and `eq_sl_o` are high. All other strobes, `busy_o` and `done_o` are low.
- R2: `start_i` is sampled high at a clock edge while idle. From the next cycle `busy_o` is high. `op_i` and all six durations are captured at that edge, and each duration is effectively max(1, value) cycles.
- R3: Precharge comes first and lasts the precharge duration: both equalizers high, nothing else but `busy_o`. Both equalizers are low before the isolation switch, the boost or the word line rise.
- R4: The isolation switch and the word-line boost are raised together for the boost duration before `wl_o` rises. Both stay high while the word line is up.
- R5: `wl_o` stays high alone (with iso/boost) for the word-line duration. `sa1_o` then rises and stays high alone for the first-stage duration, and only then does `sa2_o` rise. The two never rise in the same cycle.
- R6: For a read (op 2'b00), `csel_o` and `rd_amp_o` are high for the column duration once both sense stages are on. `rd_valid_o` is high only in the last cycle of that phase.
- R7: For a write (op 2'b01), the column phase raises `csel_o` and `wr_amp_o`. `rd_amp_o` and `rd_valid_o` stay low.
- R8: For a refresh (op 2'b10 or 2'b11), the column phase is skipped entirely. `csel_o`, `rd_amp_o`, `wr_amp_o` and `rd_valid_o` never rise.
- R9: Release takes one cycle per step in this order: column select and amplifiers drop, then `sa2_o`, then `sa1_o`, then `wl_o`, then iso and boost together. One cycle follows with nothing but `busy_o`. Then one cycle has both equalizers high, then one cycle has `done_o` with the equalizers high, and then the block is idle.
- R10: `start_i` during an access is ignored. Changes to `op_i` or to the durations after the start edge do not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access request, accepted only when idle |
| op_i | input | 2 | 00 read, 01 write, 1x refresh |
| t_pre_i | input | CW | Precharge duration in cycles |
| t_bst_i | input | CW | Isolation/boost duration in cycles |
| t_wl_i | input | CW | Word-line charge-share duration |
| t_sa1_i | input | CW | First sense stage duration |
| t_sa2_i | input | CW | Second sense stage duration |
| t_col_i | input | CW | Column phase duration |
| eq_bl_o | output | 1 | Bit-line equalizer enable |
| eq_sl_o | output | 1 | Sense-line equalizer enable |
| iso_o | output | 1 | Isolation switch enable |
| boost_o | output | 1 | Word-line boost enable |
| wl_o | output | 1 | Word line |
| sa1_o | output | 1 | First sense-amplifier stage enable |
| sa2_o | output | 1 | Second sense-amplifier stage enable |
| csel_o | output | 1 | Column select |
| rd_amp_o | output | 1 | Read amplifier connect |
| wr_amp_o | output | 1 | Write amplifier connect |
| rd_valid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished, one cycle |

## Verification
The bench runs every operation code with all durations equal at each value from zero to the maximum. This tells apart the minimum-of-one rule from plain counting and shows the full phase chain at several scales. It then sweeps one phase at a time across its range while the others stay at one, so that an off-by-one in any single phase or a swapped boundary shows up at one precise cycle. Every other access holds the start request high and scrambles the operation and durations after the start edge. This separates a correctly captured configuration from one read live.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_BST, S_WL, S_SA1, S_SA2, S_COL,
    S_R1, S_R2, S_R3, S_R4, S_R5, S_REQ, S_DONE
  } seq_st_e;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;

  // refresh is any code with the upper bit set
  function automatic logic op_is_refresh(input logic [1:0] op);
    return op[1];
  endfunction

  // fixed phase chain; refresh skips the column phase
  function automatic seq_st_e next_phase(input seq_st_e s, input logic refr);
    case (s)
      S_PRE:   return S_BST;
      S_BST:   return S_WL;
      S_WL:    return S_SA1;
      S_SA1:   return S_SA2;
      S_SA2:   return refr ? S_R1 : S_COL;
      S_COL:   return S_R1;
      S_R1:    return S_R2;
      S_R2:    return S_R3;
      S_R3:    return S_R4;
      S_R4:    return S_R5;
      S_R5:    return S_REQ;
      S_REQ:   return S_DONE;
      default: return S_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  // a loaded count of n ends the phase after exactly n+1 cycles
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !last_o) |=> !load_i || (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [CW-1:0] t_pre_i,
  input  logic [CW-1:0] t_bst_i,
  input  logic [CW-1:0] t_wl_i,
  input  logic [CW-1:0] t_sa1_i,
  input  logic [CW-1:0] t_sa2_i,
  input  logic [CW-1:0] t_col_i,
  input  logic          last_i,
  output seq_st_e       state_o,
  output logic [1:0]    op_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);
  localparam int NPH = 6;

  seq_st_e                 state_q, state_d;
  logic [1:0]              op_q;
  logic [NPH-1:0][CW-1:0]  cfg_q;
  logic                    accept;

  // a programmed length n occupies max(1,n) cycles: counter reload is n-1
  function automatic logic [CW-1:0] reload_of(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  assign accept = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (state_q == S_IDLE) begin
      if (start_i) begin
        state_d    = S_PRE;
        load_o     = 1'b1;
        load_val_o = reload_of(t_pre_i);
      end
    end else if (last_i) begin
      state_d = next_phase(state_q, op_is_refresh(op_q));
      load_o  = 1'b1;
      case (state_d)
        S_BST:   load_val_o = reload_of(cfg_q[1]);
        S_WL:    load_val_o = reload_of(cfg_q[2]);
        S_SA1:   load_val_o = reload_of(cfg_q[3]);
        S_SA2:   load_val_o = reload_of(cfg_q[4]);
        S_COL:   load_val_o = reload_of(cfg_q[5]);
        default: load_val_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q  <= op_i;
        cfg_q <= {t_col_i, t_sa2_i, t_sa1_i, t_wl_i, t_bst_i, t_pre_i};
      end
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && state_q != S_DONE) |=> state_q != S_IDLE);
  p_op_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && state_q != S_DONE) |=> $stable(op_q));
  p_refresh_nocol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_is_refresh(op_q) |-> state_q != S_COL);
  p_start_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PRE && $past(state_q) != S_PRE) |-> $past(state_q) == S_IDLE);
endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
  import dram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_st_e    state_i,
  input  logic [1:0] op_i,
  input  logic       last_i,
  output logic       eq_bl_o,
  output logic       eq_sl_o,
  output logic       iso_o,
  output logic       boost_o,
  output logic       wl_o,
  output logic       sa1_o,
  output logic       sa2_o,
  output logic       csel_o,
  output logic       rd_amp_o,
  output logic       wr_amp_o,
  output logic       rd_valid_o,
  output logic       busy_o,
  output logic       done_o
);
  logic col_ph, pump_ph, wl_ph, sa1_ph, sa2_ph, eq_ph;

  assign eq_ph   = state_i inside {S_IDLE, S_PRE, S_REQ, S_DONE};
  assign pump_ph = state_i inside {S_BST, S_WL, S_SA1, S_SA2, S_COL,
                                   S_R1, S_R2, S_R3, S_R4};
  assign wl_ph   = state_i inside {S_WL, S_SA1, S_SA2, S_COL, S_R1, S_R2, S_R3};
  assign sa1_ph  = state_i inside {S_SA1, S_SA2, S_COL, S_R1, S_R2};
  assign sa2_ph  = state_i inside {S_SA2, S_COL, S_R1};
  assign col_ph  = (state_i == S_COL);

  assign eq_bl_o    = eq_ph;
  assign eq_sl_o    = eq_ph;
  assign iso_o      = pump_ph;
  assign boost_o    = pump_ph;
  assign wl_o       = wl_ph;
  assign sa1_o      = sa1_ph;
  assign sa2_o      = sa2_ph;
  assign csel_o     = col_ph;
  assign rd_amp_o   = col_ph && (op_i == OP_READ);
  assign wr_amp_o   = col_ph && (op_i == OP_WRITE);
  assign rd_valid_o = col_ph && (op_i == OP_READ) && last_i;
  assign busy_o     = (state_i != S_IDLE);
  assign done_o     = (state_i == S_DONE);

  p_pre_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eq_bl_o) && busy_o) |-> iso_o && boost_o && !wl_o);
  p_wl_after_boost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_o) |-> $past(iso_o) && $past(boost_o) && !eq_bl_o);
  p_sa1_after_wl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sa1_o) |-> $past(wl_o) && !sa2_o);
  p_sa_stagger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sa2_o) |-> $past(sa1_o));
  p_col_after_sa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csel_o) |-> $past(sa2_o) && $past(sa1_o));
  p_valid_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !csel_o);
  p_amp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_amp_o && wr_amp_o));
  p_rev_sa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sa1_o) |-> !sa2_o && !csel_o && wl_o);
  p_rev_wl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_o) |-> iso_o && !sa1_o);
  p_done_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(eq_bl_o) && eq_bl_o && $past(busy_o));
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [CW-1:0] t_pre_i,
  input  logic [CW-1:0] t_bst_i,
  input  logic [CW-1:0] t_wl_i,
  input  logic [CW-1:0] t_sa1_i,
  input  logic [CW-1:0] t_sa2_i,
  input  logic [CW-1:0] t_col_i,
  output logic          eq_bl_o,
  output logic          eq_sl_o,
  output logic          iso_o,
  output logic          boost_o,
  output logic          wl_o,
  output logic          sa1_o,
  output logic          sa2_o,
  output logic          csel_o,
  output logic          rd_amp_o,
  output logic          wr_amp_o,
  output logic          rd_valid_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_st_e       phase_w;
  logic [1:0]    op_w;
  logic          load_w;
  logic [CW-1:0] load_val_w;
  logic          last_w;

  dram_seq_fsm #(.CW(CW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .t_pre_i(t_pre_i), .t_bst_i(t_bst_i), .t_wl_i(t_wl_i),
    .t_sa1_i(t_sa1_i), .t_sa2_i(t_sa2_i), .t_col_i(t_col_i),
    .last_i(last_w), .state_o(phase_w), .op_o(op_w),
    .load_o(load_w), .load_val_o(load_val_w)
  );

  dram_seq_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_w),
    .load_val_i(load_val_w), .last_o(last_w)
  );

  dram_seq_strobe strobe_i (
    .clk(clk), .rst_n(rst_n), .state_i(phase_w), .op_i(op_w), .last_i(last_w),
    .eq_bl_o(eq_bl_o), .eq_sl_o(eq_sl_o), .iso_o(iso_o), .boost_o(boost_o),
    .wl_o(wl_o), .sa1_o(sa1_o), .sa2_o(sa2_o), .csel_o(csel_o),
    .rd_amp_o(rd_amp_o), .wr_amp_o(wr_amp_o), .rd_valid_o(rd_valid_o),
    .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: tb/dram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_seq_ctrl_tb_top;
  localparam int CW = 2;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [CW-1:0] t_pre = '0, t_bst = '0, t_wl = '0, t_sa1 = '0, t_sa2 = '0, t_col = '0;
  logic eq_bl, eq_sl, iso, boost, wl, sa1, sa2, csel, rd_amp, wr_amp, rd_valid, busy, done;

  int checks = 0;
  int fails  = 0;
  int n [6];
  logic [12:0] exp_v;
  string exp_tag;

  always #4 clk = ~clk;

  dram_seq_ctrl #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .t_pre_i(t_pre), .t_bst_i(t_bst), .t_wl_i(t_wl),
    .t_sa1_i(t_sa1), .t_sa2_i(t_sa2), .t_col_i(t_col),
    .eq_bl_o(eq_bl), .eq_sl_o(eq_sl), .iso_o(iso), .boost_o(boost), .wl_o(wl),
    .sa1_o(sa1), .sa2_o(sa2), .csel_o(csel), .rd_amp_o(rd_amp), .wr_amp_o(wr_amp),
    .rd_valid_o(rd_valid), .busy_o(busy), .done_o(done)
  );

  // bit order: eq_bl eq_sl iso boost wl sa1 sa2 csel rd_amp wr_amp rd_valid busy done
  function automatic logic [12:0] outv();
    return {eq_bl, eq_sl, iso, boost, wl, sa1, sa2, csel, rd_amp, wr_amp, rd_valid, busy, done};
  endfunction

  function automatic int eff(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int access_len(input int o);
    int s = eff(n[0]) + eff(n[1]) + eff(n[2]) + eff(n[3]) + eff(n[4]);
    if (o < 2) s += eff(n[5]);
    return s + 7;
  endfunction

  // expected outputs k cycles after the accepting edge (k >= 1)
  task automatic model(input int o, input int k);
    int c = 0;
    bit rf = (o >= 2);
    exp_v = 13'b1100000000000; exp_tag = "R1";
    c += eff(n[0]);
    if (k <= c) begin exp_v = 13'b1100000000010; exp_tag = "R3"; return; end
    c += eff(n[1]);
    if (k <= c) begin exp_v = 13'b0011000000010; exp_tag = "R4"; return; end
    c += eff(n[2]);
    if (k <= c) begin exp_v = 13'b0011100000010; exp_tag = "R5"; return; end
    c += eff(n[3]);
    if (k <= c) begin exp_v = 13'b0011110000010; exp_tag = "R5"; return; end
    c += eff(n[4]);
    if (k <= c) begin exp_v = 13'b0011111000010; exp_tag = "R5"; return; end
    if (!rf) begin
      c += eff(n[5]);
      if (k <= c) begin
        if (o == 0) begin
          exp_v = 13'b0011111110010; exp_tag = "R6";
          if (k == c) exp_v[2] = 1'b1;
        end else begin
          exp_v = 13'b0011111101010; exp_tag = "R7";
        end
        return;
      end
    end
    exp_tag = rf ? "R8" : "R9";
    if (k == c + 1) begin exp_v = 13'b0011111000010; return; end
    if (k == c + 2) begin exp_v = 13'b0011110000010; return; end
    if (k == c + 3) begin exp_v = 13'b0011100000010; return; end
    if (k == c + 4) begin exp_v = 13'b0011000000010; return; end
    if (k == c + 5) begin exp_v = 13'b0000000000010; return; end
    if (k == c + 6) begin exp_v = 13'b1100000000010; return; end
    if (k == c + 7) begin exp_v = 13'b1100000000011; return; end
    exp_v = 13'b1100000000000; exp_tag = "R2";
  endtask

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] expd);
    checks++;
    if (act !== expd) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", tag, act, expd);
    end
  endtask

  // one access; hold=1 keeps start high and scrambles inputs after acceptance (R10)
  task automatic run_access(input int o, input bit hold);
    int len;
    @(negedge clk);
    op = o[1:0];
    t_pre = n[0][CW-1:0]; t_bst = n[1][CW-1:0]; t_wl = n[2][CW-1:0];
    t_sa1 = n[3][CW-1:0]; t_sa2 = n[4][CW-1:0]; t_col = n[5][CW-1:0];
    start = 1'b1;
    len = access_len(o);
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = hold;
        if (hold) begin
          op = ~o[1:0];
          t_pre = '1; t_bst = '0; t_wl = '1; t_sa1 = '0; t_sa2 = '1; t_col = '0;
        end
      end
      model(o, k);
      check((hold && k > 1 && k <= len) ? "R10" : exp_tag, outv(), exp_v);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", outv(), 13'b1100000000000);   // in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outv(), 13'b1100000000000);
    for (int o = 0; o < 4; o++) begin
      // R2: all durations equal, incl. zero
      for (int v = 0; v <= MAXV; v++) begin
        for (int p = 0; p < 6; p++) n[p] = v;
        run_access(o, hold);
        hold = !hold;
      end
      // per-phase sweep, others at one
      for (int p = 0; p < 6; p++) begin
        for (int v = 0; v <= MAXV; v++) begin
          for (int q = 0; q < 6; q++) n[q] = 1;
          n[p] = v;
          run_access(o, hold);
          hold = !hold;
        end
      end
    end
    @(negedge clk);
    check("R1", outv(), 13'b1100000000000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule